// File: doc/BRIEF.md
# Flash Program/Erase Status Generator

This block forms the status word that a flash device returns on read cycles while an embedded program or erase algorithm runs. It sits between the algorithm sequencer and the read data path. The sequencer reports when an algorithm is accepted, whether it is a program or an erase, and whether a sector-erase loading window is open. It also reports when an erase is suspended, when verification has passed, and when a reset command arrives. The block also receives bit 7 of the byte being programmed and a one-cycle read strobe for each read access.

While an algorithm is active, the data outputs carry a status word in place of array data. Bit 7 is a polling bit. Bit 6 changes on every read. Bit 5 is a sticky flag that the pulse limit was exceeded. Bit 3 reports whether the internal erase has started. At all other times the array data input passes straight through.

An internal pulse counter stands in for the analog pulse loop. It counts a parameterised number of clock cycles per pulse and a parameterised number of pulses. When the limit is reached, the operation is marked as failed and stays active until a reset command. An active-low ready/busy output is low while programming or while an erase is running.

Top module: `flash_status_gen`

## Requirements
- R1: With no algorithm active, `data_out` equals `array_data` and `ready_busy` is 1. This is also the state after reset.
- R2: While a program is active, `data_out[7]` is the inverse of the `wr_poll_bit` captured when the program was accepted. After `verify_done` ends the program, array data passes through again.
- R3: While an erase is running (not suspended, no program active), `data_out[7]` is 0.
- R4: `data_out[6]` is a toggle value. It is cleared to 0 when any algorithm is accepted. It inverts once per `rd_stb` cycle only while the status word is presented, so successive status reads alternate 0,1,0,...
- R5: After CYCLES_PER_PULSE*PULSE_LIMIT counting cycles without `verify_done`, `data_out[5]` becomes 1. It then stays 1 and the status word stays presented, ignoring `verify_done`, until `reset_cmd` clears the operation.
- R6: `data_out[3]` is 0 while the program status is shown or while `window_open` is 1 during an erase. It is 1 while an erase runs with the window closed.
- R7: `ready_busy` is 0 while a program is active, including a program accepted during an erase suspend, and while an erase runs unsuspended.
- R8: While an erase is suspended and no program is active, `ready_busy` is 1 and `data_out` equals `array_data`.
- R9: A `start` is ignored while a program is active, while an erase is running, or after a timeout. The one exception is a program start (`op_erase`=0) while an erase is suspended.
- R10: The erase pulse counter does not advance while `window_open` is 1 or while the erase is suspended. Counting resumes from where it stopped.
- R11: Status bits 4, 2, 1 and 0 always read 0 while the status word is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Sequencer requests a new algorithm (one cycle) |
| op_erase | input | 1 | 0 = program, 1 = erase, qualifies `start` |
| wr_poll_bit | input | 1 | Bit 7 of the data being programmed |
| window_open | input | 1 | Sector-erase loading window still open |
| erase_susp | input | 1 | Erase is suspended (level) |
| verify_done | input | 1 | Verification passed; ends the active algorithm |
| reset_cmd | input | 1 | Reset command; aborts and clears a timeout |
| rd_stb | input | 1 | One cycle per read access |
| array_data | input | 8 | Array read data |
| data_out | output | 8 | Read data: status word or array data |
| ready_busy | output | 1 | 1 = ready, 0 = busy |

## Verification
The assertions assume that the sequencer behaves sensibly at the block's edge. It raises `verify_done` only while some algorithm is active, and it holds `erase_susp` only while an erase is in progress. It opens `window_open` only around an erase, and it pulses `start` for a single cycle. The stimulus follows these rules. It changes inputs only on the falling clock edge, asserts `verify_done` only in cycles where an algorithm is active, and raises `erase_susp` or `window_open` only inside an erase. The pulse parameters are set small, so the timeout and the counter pause are exercised in a few dozen cycles.

// File: rtl/flash_status_pkg.sv
// Shared definitions for the flash status generator.
// Assumes an 8-bit read data path; bit positions are fixed by the status word layout.
package flash_status_pkg;

    localparam int DATA_W     = 8;
    localparam int POLL_POS   = 7;
    localparam int TOGGLE_POS = 6;
    localparam int LIMIT_POS  = 5;
    localparam int ERASE_POS  = 3;

    // What the read path presents in the current cycle
    typedef enum logic [1:0] {
        VIEW_ARRAY = 2'd0,
        VIEW_PROG  = 2'd1,
        VIEW_ERASE = 2'd2
    } view_e;

endpackage

// File: rtl/fsg_pulse_timer.sv
// Pulse-count limit timer.
// Counts enabled cycles in groups of CYCLES_PER_PULSE; after PULSE_LIMIT groups the
// expired flag sets and holds until clear. Assumes clear and enable are not both
// needed in one cycle (clear wins).
module fsg_pulse_timer #(
    parameter int CYCLES_PER_PULSE = 16,
    parameter int PULSE_LIMIT      = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic enable,
    output logic expired
);

    localparam int CW = (CYCLES_PER_PULSE > 1) ? $clog2(CYCLES_PER_PULSE) : 1;
    localparam int PW = $clog2(PULSE_LIMIT + 1);
    localparam logic [CW-1:0] CYC_LAST   = CW'(CYCLES_PER_PULSE - 1);
    localparam logic [PW-1:0] PULSE_LAST = PW'(PULSE_LIMIT - 1);

    logic [CW-1:0] cyc_cnt;
    logic [PW-1:0] pulse_cnt;

    // Advance the cycle and pulse counters; latch expiry when the last pulse ends
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cyc_cnt   <= '0;
            pulse_cnt <= '0;
            expired   <= 1'b0;
        end else if (enable && !expired) begin
            if (cyc_cnt == CYC_LAST) begin
                cyc_cnt   <= '0;
                pulse_cnt <= pulse_cnt + 1'b1;
                if (pulse_cnt == PULSE_LAST) begin
                    expired <= 1'b1;
                end
            end else begin
                cyc_cnt <= cyc_cnt + 1'b1;
            end
        end
    end

    // R5: once expired, only clear removes the flag
    assert_limit_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !clear) |=> expired);

    // R10: a disabled timer never newly expires
    assert_no_count_paused_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !expired && !clear) |=> !expired);

endmodule

// File: rtl/fsg_toggle.sv
// Toggle bit source: inverts once per qualified read, cleared when an algorithm starts.
// Assumes advance is already qualified with "status word presented".
module fsg_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic advance,
    output logic tog
);

    // Flip on each qualified read; clear has priority
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            tog <= 1'b0;
        end else if (advance) begin
            tog <= ~tog;
        end
    end

    // R4: each qualified read changes the value seen by the next read
    assert_toggle_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !clear) |=> (tog != $past(tog)));

    // R4: a new algorithm always begins with toggle at 0
    assert_toggle_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !tog);

endmodule

// File: rtl/fsg_status_word.sv
// Read data multiplexer: forms the status word for the selected view, or passes
// array data. Purely combinational; assumes inputs are stable within a cycle.
module fsg_status_word
    import flash_status_pkg::*;
(
    input  view_e             view,
    input  logic              poll_src,
    input  logic              tog,
    input  logic              limit_hit,
    input  logic              window_open,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] data_out
);

    // Select array data or assemble the per-operation status bits
    always_comb begin
        data_out = '0;
        unique case (view)
            VIEW_PROG: begin
                data_out[POLL_POS]   = ~poll_src;
                data_out[TOGGLE_POS] = tog;
                data_out[LIMIT_POS]  = limit_hit;
            end
            VIEW_ERASE: begin
                data_out[POLL_POS]   = 1'b0;
                data_out[TOGGLE_POS] = tog;
                data_out[LIMIT_POS]  = limit_hit;
                data_out[ERASE_POS]  = ~window_open;
            end
            default: data_out = array_data;
        endcase
    end

endmodule

// File: rtl/flash_status_gen.sv
// Flash program/erase status generator (top).
// Tracks the active program and erase, runs one pulse-limit timer for each, and
// drives the read data path and ready/busy. Assumes the sequencer pulses start
// for one cycle and raises verify_done only while an algorithm is active.
module flash_status_gen
    import flash_status_pkg::*;
#(
    parameter int CYCLES_PER_PULSE = 16,
    parameter int PULSE_LIMIT      = 1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        op_erase,
    input  logic        wr_poll_bit,
    input  logic        window_open,
    input  logic        erase_susp,
    input  logic        verify_done,
    input  logic        reset_cmd,
    input  logic        rd_stb,
    input  logic [7:0]  array_data,
    output logic [7:0]  data_out,
    output logic        ready_busy
);

    localparam int N_TMR   = 2;
    localparam int TMR_PRG = 0;
    localparam int TMR_ERS = 1;

    logic             prog_run, erase_run, poll_q;
    logic             accept_prog, accept_erase, timed_out, tog;
    logic [N_TMR-1:0] tmr_clear, tmr_en, tmr_exp;
    view_e            view;

    assign timed_out    = |tmr_exp;
    assign accept_prog  = start && !op_erase && !prog_run && !timed_out
                          && (!erase_run || erase_susp);
    assign accept_erase = start && op_erase && !prog_run && !erase_run && !timed_out;

    // Program state: set on an accepted program, ended by verify or reset command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_run <= 1'b0;
            poll_q   <= 1'b0;
        end else if (reset_cmd) begin
            prog_run <= 1'b0;
        end else if (accept_prog) begin
            prog_run <= 1'b1;
            poll_q   <= wr_poll_bit;
        end else if (verify_done && prog_run && !timed_out) begin
            prog_run <= 1'b0;
        end
    end

    // Erase state: set on an accepted erase, ended by verify while it runs, or reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            erase_run <= 1'b0;
        end else if (reset_cmd) begin
            erase_run <= 1'b0;
        end else if (accept_erase) begin
            erase_run <= 1'b1;
        end else if (verify_done && erase_run && !prog_run && !erase_susp
                     && !window_open && !timed_out) begin
            erase_run <= 1'b0;
        end
    end

    assign tmr_clear[TMR_PRG] = accept_prog || reset_cmd;
    assign tmr_en[TMR_PRG]    = prog_run;
    assign tmr_clear[TMR_ERS] = accept_erase || reset_cmd;
    assign tmr_en[TMR_ERS]    = erase_run && !erase_susp && !window_open && !prog_run;

    // One pulse-limit timer per algorithm so a suspend-time program keeps the erase count
    for (genvar gi = 0; gi < N_TMR; gi++) begin : g_tmr
        fsg_pulse_timer #(
            .CYCLES_PER_PULSE (CYCLES_PER_PULSE),
            .PULSE_LIMIT      (PULSE_LIMIT)
        ) tmr_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (tmr_clear[gi]),
            .enable  (tmr_en[gi]),
            .expired (tmr_exp[gi])
        );
    end

    // Choose what the read path shows this cycle
    always_comb begin
        if (prog_run) begin
            view = VIEW_PROG;
        end else if (erase_run && (!erase_susp || tmr_exp[TMR_ERS])) begin
            view = VIEW_ERASE;
        end else begin
            view = VIEW_ARRAY;
        end
    end

    fsg_toggle tog_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept_prog || accept_erase),
        .advance (rd_stb && (view != VIEW_ARRAY)),
        .tog     (tog)
    );

    fsg_status_word word_i (
        .view        (view),
        .poll_src    (poll_q),
        .tog         (tog),
        .limit_hit   (timed_out),
        .window_open (window_open),
        .array_data  (array_data),
        .data_out    (data_out)
    );

    assign ready_busy = !(prog_run || (erase_run && !erase_susp));

    // R2: polling bit after a program is accepted is the inverse of the captured bit
    assert_prog_poll_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept_prog |=> (data_out[7] == !$past(wr_poll_bit)));

    // R3: a running erase polls 0
    assert_erase_poll_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_run && !erase_susp && !prog_run) |-> (data_out[7] == 1'b0));

    // R6: erase-started bit follows the window while an erase runs
    assert_window_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_run && !erase_susp && !prog_run) |-> (data_out[3] == !window_open));

    // R7: an accepted program makes the block busy next cycle
    assert_prog_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        accept_prog |=> !ready_busy);

    // R8: a suspended erase is ready and passes array data
    assert_susp_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_run && erase_susp && !prog_run && !tmr_exp[TMR_ERS])
        |-> (ready_busy && data_out == array_data));

    // R9: only verify or reset ends a program; a new start cannot
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_run && !verify_done && !reset_cmd) |=> prog_run);

    // R11: unused status bits stay 0 whenever busy
    assert_spare_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_busy |-> (data_out[4] == 1'b0 && data_out[2:0] == 3'b000));

endmodule

// File: tb/flash_status_gen_tb.sv
// Testbench: a stimulus/expectation table walked by one loop, then directed tests.
module flash_status_gen_tb_top;

    localparam int CPP   = 4;
    localparam int LIMIT = 3;
    localparam int SPAN  = CPP * LIMIT;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start, op_erase, wr_poll_bit, window_open, erase_susp;
    logic       verify_done, reset_cmd, rd_stb;
    logic [7:0] array_data, data_out;
    logic       ready_busy;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #10 clk = ~clk;

    flash_status_gen #(.CYCLES_PER_PULSE(CPP), .PULSE_LIMIT(LIMIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op_erase(op_erase),
        .wr_poll_bit(wr_poll_bit), .window_open(window_open), .erase_susp(erase_susp),
        .verify_done(verify_done), .reset_cmd(reset_cmd), .rd_stb(rd_stb),
        .array_data(array_data), .data_out(data_out), .ready_busy(ready_busy)
    );

    typedef struct packed {
        logic       st;
        logic       ers;
        logic       pb;
        logic       win;
        logic       sus;
        logic       vd;
        logic       rc;
        logic       rd;
        logic [7:0] arr;
        logic [7:0] exp_d;
        logic       exp_rb;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VECS [NV] = '{
        // st ers pb win sus vd rc rd arr    exp    rb
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h5A,8'h5A,1'b1}, // 0 R1 idle
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,8'h5A,8'h5A,1'b1}, // 1 program start
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,8'hFF,8'h00,1'b0}, // 2 R2 R4 R7
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,8'hFF,8'h40,1'b0}, // 3 R4
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,8'hFF,8'h00,1'b0}, // 4 R4
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'hFF,8'h40,1'b0}, // 5 verify
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,8'hC3,8'hC3,1'b1}, // 6 R2 pass
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'hC3,8'hC3,1'b1}, // 7 program bit7=0
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'hC3,8'h80,1'b0}, // 8 R2 R4 clear
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'hC3,8'h80,1'b0}, // 9 verify
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h11,8'h11,1'b1}, // 10 R1
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'hFF,8'hFF,1'b1}, // 11 erase start
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,8'hFF,8'h08,1'b0}, // 12 R3 R6 R11
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,8'hFF,8'h48,1'b0}, // 13 R4
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'hFF,8'h08,1'b0}, // 14 verify
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'hFF,8'hFF,1'b1}, // 15 R1
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,8'hFF,8'hFF,1'b1}, // 16 sector erase
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,8'hFF,8'h00,1'b0}, // 17 R6 window
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,8'hFF,8'h40,1'b0}, // 18 R4
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'hFF,8'h08,1'b0}, // 19 R6 started
        '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,8'h77,8'h77,1'b1}, // 20 R8 suspend
        '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,8'h77,8'h77,1'b1}, // 21 R8 R4 no step
        '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,8'h77,8'h77,1'b1}, // 22 R9 program in suspend
        '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,8'h77,8'h00,1'b0}, // 23 R7
        '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,8'h77,8'h00,1'b0}, // 24 R7
        '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,8'h77,8'h40,1'b0}, // 25 verify
        '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,8'h80,8'h80,1'b1}, // 26 R8
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h80,8'h48,1'b0}, // 27 resume R3
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'h80,8'h48,1'b0}, // 28 verify
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'hFF,8'hFF,1'b1}  // 29 R1
    };

    task automatic drive(input logic st, input logic ers, input logic pb, input logic win,
                         input logic sus, input logic vd, input logic rc, input logic rd,
                         input logic [7:0] arr);
        @(negedge clk);
        start = st; op_erase = ers; wr_poll_bit = pb; window_open = win;
        erase_susp = sus; verify_done = vd; reset_cmd = rc; rd_stb = rd; array_data = arr;
        #5;
    endtask

    task automatic check(input string req, input logic [7:0] exp_d, input logic exp_rb);
        checks++;
        if (data_out !== exp_d || ready_busy !== exp_rb) begin
            errors++;
            $display("FAIL %s: data_out=%h ready_busy=%b expected data_out=%h ready_busy=%b",
                     req, data_out, ready_busy, exp_d, exp_rb);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        logic t;
        rst_n = 1'b0;
        drive(0, 0, 0, 0, 0, 0, 0, 0, 8'hA5);
        drive(0, 0, 0, 0, 0, 0, 0, 0, 8'hA5);
        check("R1 reset", 8'hA5, 1'b1);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].st, VECS[i].ers, VECS[i].pb, VECS[i].win, VECS[i].sus,
                  VECS[i].vd, VECS[i].rc, VECS[i].rd, VECS[i].arr);
            check($sformatf("table step %0d", i), VECS[i].exp_d, VECS[i].exp_rb);
        end

        // R5: program that never verifies (non-blank target) times out, toggle keeps going
        drive(1, 0, 0, 0, 0, 0, 0, 0, 8'h00);
        t = 1'b0;
        for (int k = 1; k <= SPAN + 4; k++) begin
            drive(0, 0, 0, 0, 0, 0, 0, 1, 8'h00);
            check($sformatf("R5 timeout cycle %0d", k),
                  8'h80 | (8'(t) << 6) | ((k > SPAN) ? 8'h20 : 8'h00), 1'b0);
            t = ~t;
        end
        drive(0, 0, 0, 0, 0, 1, 0, 0, 8'h00);
        check("R5 verify ignored", 8'hA0 | (8'(t) << 6), 1'b0);
        drive(0, 1, 0, 0, 0, 0, 0, 0, 8'h00);
        drive(1, 1, 0, 0, 0, 0, 0, 0, 8'h00);
        drive(0, 0, 0, 0, 0, 0, 0, 0, 8'h00);
        check("R9 start ignored after timeout", 8'hA0 | (8'(t) << 6), 1'b0);
        drive(0, 0, 0, 0, 0, 0, 1, 0, 8'h00);
        drive(0, 0, 0, 0, 0, 0, 0, 0, 8'h3C);
        check("R5 reset command clears", 8'h3C, 1'b1);

        // R10: erase counting pauses during window and suspend
        drive(1, 1, 0, 1, 0, 0, 0, 0, 8'h3C);
        for (int k = 0; k < 20; k++) begin
            drive(0, 0, 0, 1, 0, 0, 0, 0, 8'h3C);
            check("R10 window no count", 8'h00, 1'b0);
        end
        for (int k = 0; k < SPAN / 2; k++) begin
            drive(0, 0, 0, 0, 0, 0, 0, 0, 8'h3C);
            check("R10 counting", 8'h08, 1'b0);
        end
        for (int k = 0; k < 10; k++) begin
            drive(0, 0, 0, 0, 1, 0, 0, 0, 8'h3C);
            check("R10 suspend pass", 8'h3C, 1'b1);
        end
        for (int k = 1; k <= SPAN - SPAN / 2 + 1; k++) begin
            drive(0, 0, 0, 0, 0, 0, 0, 0, 8'h3C);
            check("R10 resumed count", (k > SPAN - SPAN / 2) ? 8'h28 : 8'h08, 1'b0);
        end
        drive(0, 0, 0, 0, 0, 0, 1, 0, 8'h3C);

        // R9: program start during a running erase is ignored
        drive(1, 1, 0, 0, 0, 0, 0, 0, 8'h3C);
        drive(1, 0, 0, 0, 0, 0, 0, 0, 8'h3C);
        check("R9 erase view before", 8'h08, 1'b0);
        drive(0, 0, 0, 0, 0, 0, 0, 0, 8'h3C);
        check("R9 program start ignored", 8'h08, 1'b0);
        drive(0, 0, 0, 0, 0, 1, 0, 0, 8'h3C);
        drive(0, 0, 0, 0, 0, 0, 0, 0, 8'h3C);
        check("R1 after erase verify", 8'h3C, 1'b1);

        finish_run();
    end

endmodule